// File: doc/BRIEF.md
# Packed BCD Adder with Bias Correction

This block adds two packed decimal operands, sixteen digits of four bits each by default, and returns the packed decimal sum and a decimal carry out of the top digit. It does not adjust each digit in turn. It runs one wide binary addition on the inputs, with 6 already added to every digit of the first operand. It then recovers the carry that entered each digit from the bit-0 parity of the operands and the raw sum. Finally it takes the 6 back out of every digit that did not carry.

The interface is a single registered stage with no handshake. Operands presented with `in_valid_i` produce a registered sum and carry one clock later, marked by a one-cycle `out_valid_o`. Subtraction, signed forms, carry-in chaining and the screening of illegal digit codes are outside this block.

Top module: `bcd_adder`

## Requirements
- R1: For operands whose digits are all 0 to 9, `sum_o` equals (A + B) mod 10^16, with each digit at nibble n (bits 4n+3..4n, digit 0 least significant).
- R2: `carry_o` is 1 exactly when the decimal value A + B is at least 10^16, and is 0 otherwise.
- R3: All nines (0x9999999999999999) plus one gives a sum of zero with `carry_o` = 1.
- R4: A pattern of alternating 9 and 0 digits added to its digit-wise complement gives all nines with `carry_o` = 0. 0x9090909090909090 added to itself gives 0x8181818181818180 with `carry_o` = 1.
- R5: When both operands are legal, every nibble of `sum_o` is in the range 0 to 9.
- R6: `out_valid_o` is 1 in the cycle after an edge that samples `in_valid_i` = 1, and is 0 after an edge that samples `in_valid_i` = 0.
- R7: When `in_valid_i` is 0, `sum_o` and `carry_o` keep their previous values.
- R8: While `rst_ni` is low, `out_valid_o`, `sum_o` and `carry_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid this cycle |
| a_i | input | 64 | Packed BCD operand A |
| b_i | input | 64 | Packed BCD operand B |
| out_valid_o | output | 1 | Result valid, one cycle after the input |
| sum_o | output | 64 | Packed BCD sum |
| carry_o | output | 1 | Decimal carry out of the top digit |

## Verification
Every result is due one clock edge after the edge that samples `in_valid_i`. The bench drives the operands on a falling edge and lets the next rising edge capture them. It then reads `sum_o`, `carry_o` and `out_valid_o` on the falling edge that follows, and compares them with a digit-by-digit decimal reference. On the next falling edge, with `in_valid_i` low, it checks that `out_valid_o` has dropped and that the sum and carry have held their values.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;
  localparam int unsigned NIB_W    = 4;
  localparam logic [3:0]  BIAS_NIB = 4'h6;
endpackage

// File: rtl/bcd_bias_add.sv
// Biased binary add; extracts the carry into each digit from bit-0 parity.
module bcd_bias_add
  import bcd_add_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  localparam int unsigned DW  = NDIG * NIB_W
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   s_o,
  output logic            cout_o,
  output logic [NDIG-1:1] dig_cin_o
);
  logic [DW-1:0] a_bias;

  assign a_bias         = a_i + {NDIG{BIAS_NIB}};
  assign {cout_o, s_o}  = {1'b0, a_bias} + {1'b0, b_i};

  // 6 is even, so the bias leaves bit-0 parity untouched
  for (genvar n = 1; n < NDIG; n++) begin : g_cin
    assign dig_cin_o[n] = a_bias[n*NIB_W] ^ b_i[n*NIB_W] ^ s_o[n*NIB_W];
  end
endmodule

// File: rtl/bcd_nocarry_flags.sv
// Marks, at bit 3 of nibble n, each digit that produced no carry.
module bcd_nocarry_flags
  import bcd_add_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  localparam int unsigned DW  = NDIG * NIB_W
) (
  input  logic [NDIG-1:1] dig_cin_i,
  input  logic            cout_i,
  output logic [DW-1:0]   flag_o
);
  for (genvar n = 0; n < NDIG; n++) begin : g_flag
    assign flag_o[n*NIB_W +: 3] = 3'b000;
    if (n == NDIG - 1) begin : g_top
      assign flag_o[n*NIB_W + 3] = ~cout_i;
    end else begin : g_mid
      assign flag_o[n*NIB_W + 3] = ~dig_cin_i[n+1];
    end
  end
endmodule

// File: rtl/bcd_bias_remove.sv
// Removes 6 (= 4 + 2) from flagged digits; a flag at bit 3 shifted down gives both weights.
module bcd_bias_remove
  import bcd_add_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  localparam int unsigned DW  = NDIG * NIB_W
) (
  input  logic [DW-1:0] s_i,
  input  logic [DW-1:0] flag_i,
  output logic [DW-1:0] res_o
);
  assign res_o = s_i - (flag_i >> 1) - (flag_i >> 2);
endmodule

// File: rtl/bcd_adder.sv
module bcd_adder
  import bcd_add_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  localparam int unsigned DW  = NDIG * NIB_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          out_valid_o,
  output logic [DW-1:0] sum_o,
  output logic          carry_o
);
  logic [DW-1:0]   s_raw;
  logic            cout;
  logic [NDIG-1:1] dig_cin;
  logic [DW-1:0]   flag;
  logic [DW-1:0]   res;

  bcd_bias_add #(.NDIG(NDIG)) u_add (
    .a_i(a_i), .b_i(b_i), .s_o(s_raw), .cout_o(cout), .dig_cin_o(dig_cin)
  );

  bcd_nocarry_flags #(.NDIG(NDIG)) u_flags (
    .dig_cin_i(dig_cin), .cout_i(cout), .flag_o(flag)
  );

  bcd_bias_remove #(.NDIG(NDIG)) u_fix (
    .s_i(s_raw), .flag_i(flag), .res_o(res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      sum_o       <= '0;
      carry_o     <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        sum_o   <= res;
        carry_o <= cout;
      end
    end
  end
endmodule

// File: rtl/bcd_adder_chk.sv
module bcd_adder_chk
  import bcd_add_pkg::*;
#(
  parameter int unsigned NDIG = 16,
  localparam int unsigned DW  = NDIG * NIB_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic          out_valid_o,
  input logic [DW-1:0] sum_o,
  input logic          carry_o
);
  function automatic logic is_bcd(input logic [DW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int n = 0; n < NDIG; n++) if (v[n*NIB_W +: NIB_W] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  p_valid_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  p_valid_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(sum_o) && $stable(carry_o)));

  p_legal_bcd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && is_bcd(a_i) && is_bcd(b_i)) |=> is_bcd(sum_o));

  p_zero_add_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && a_i == '0 && b_i == '0) |=> (sum_o == '0 && !carry_o));

  // R8: reset state
  always @(posedge clk_i)
    if (!rst_ni) p_reset_r8: assert (!out_valid_o && sum_o == '0 && !carry_o);
endmodule

bind bcd_adder bcd_adder_chk #(.NDIG(NDIG)) u_chk (.*);

// File: tb/sim_bcd_adder.sv
module sim_bcd_adder;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG       = 16;
  localparam int DW         = NDIG * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] a = '0;
  logic [DW-1:0] b = '0;
  logic          out_valid;
  logic [DW-1:0] sum;
  logic          carry;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_adder #(.NDIG(NDIG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .a_i(a), .b_i(b),
    .out_valid_o(out_valid), .sum_o(sum), .carry_o(carry)
  );

  function automatic void ref_add(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                  output logic [DW-1:0] s, output logic c);
    int t;
    c = 1'b0;
    for (int n = 0; n < NDIG; n++) begin
      t = int'(x[n*4 +: 4]) + int'(y[n*4 +: 4]) + int'(c);
      c = (t >= 10);
      if (c) t = t - 10;
      s[n*4 +: 4] = 4'(t);
    end
  endfunction

  function automatic logic [DW-1:0] rnd_bcd();
    logic [DW-1:0] v;
    for (int n = 0; n < NDIG; n++) v[n*4 +: 4] = 4'($urandom % 10);
    return v;
  endfunction

  function automatic logic legal(input logic [DW-1:0] v);
    for (int n = 0; n < NDIG; n++) if (v[n*4 +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [DW-1:0] x, input logic [DW-1:0] y, input string req);
    logic [DW-1:0] es;
    logic          ec;
    ref_add(x, y, es, ec);
    @(negedge clk);
    a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    a = rnd_bcd(); b = rnd_bcd();
    check({req, " sum (R1)"}, {1'b0, sum}, {1'b0, es});
    check({req, " carry (R2)"}, {{DW{1'b0}}, carry}, {{DW{1'b0}}, ec});
    check("R6 valid high", {{DW{1'b0}}, out_valid}, {{DW{1'b0}}, 1'b1});
    check("R5 legal digits", {{DW{1'b0}}, legal(sum)}, {{DW{1'b0}}, 1'b1});
    @(negedge clk);
    check("R6 valid low", {{DW{1'b0}}, out_valid}, '0);
    check("R7 hold", {carry, sum}, {ec, es});
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_fail++;
    $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    in_valid = 1'b1; a = rnd_bcd(); b = rnd_bcd();
    @(negedge clk);
    check("R8 reset valid", {{DW{1'b0}}, out_valid}, '0);
    check("R8 reset data", {carry, sum}, '0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    apply('0, '0, "zeros");
    apply({NDIG{4'h9}}, 64'h1, "R3 nines+1");
    check("R3 direct", {carry, sum}, {1'b1, {DW{1'b0}}});
    apply({(NDIG/2){8'h90}}, {(NDIG/2){8'h09}}, "R4 alt+comp");
    check("R4 alt+comp", {carry, sum}, {1'b0, {NDIG{4'h9}}});
    apply({(NDIG/2){8'h90}}, {(NDIG/2){8'h90}}, "R4 alt+alt");
    check("R4 alt+alt", {carry, sum}, {1'b1, 64'h8181818181818180});
    apply({NDIG{4'h9}}, {NDIG{4'h9}}, "nines+nines");
    apply({NDIG{4'h5}}, {NDIG{4'h5}}, "fives");
    apply(64'h1, {NDIG{4'h9}}, "one+nines");

    for (int i = 0; i < 300; i++) apply(rnd_bcd(), rnd_bcd(), "random");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule